// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One down-counting timer channel of the classic three-channel interval timer family. The host supplies an operating mode (0 to 5) and an initial count N through a single-cycle load strobe. From then on the channel counts input ticks and drives one output pin with the waveform of that mode. The waveforms are a terminal-count level, a one-shot level, a single-tick rate pulse, a square wave and a single-tick strobe. The current down-count value is also presented.

Ticks are qualified by a clock-enable input, so the channel runs on the system clock at any slower count rate. In the periodic modes the gate input pauses counting. The gate is registered on every clock, and its reset value is a parameter, so one module serves channels whose gate idles high or low. A programmed count of zero stands for 2^CW ticks (65536 with the default width).

The load strobe and tick enable are plain control pins. There is no back-pressure: a load is taken on the cycle it is asserted. Elapsed ticks d are counted from the most recent load. The output is defined purely as a function of d and N.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset, the mode is 3 and N is 65536. Right after reset, out_o is 1 and count_o is 0. The registered gate starts at parameter GATE_RST.
- R2: Mode 0: out_o is 0 while d < N and 1 once d >= N. It stays 1 until the next load.
- R3: Mode 1: out_o is 1 while d < N and 0 once d >= N.
- R4: Mode 2: out_o is 1 exactly when d is nonzero and d mod N is 0, and 0 otherwise.
- R5: Mode 3: out_o is 1 while (d mod N) < (N+1)>>1, and 0 otherwise. An odd N gives the extra tick to the high phase.
- R6: Modes 4 and 5: out_o is 1 only while d equals N, and 0 before and after.
- R7: A loaded count of 0 is treated as N = 65536.
- R8: A load sets the mode and N and restarts d at 0. count_o equals the loaded count on the next cycle, and a load wins over a tick in the same cycle.
- R9: d advances only on clock edges where tick_i is 1. Without a tick or a load, out_o and count_o hold.
- R10: In modes 2, 3, 6 and 7, a tick counts only if gate_i was 1 on the previous clock edge. In modes 0, 1, 4 and 5 the gate is ignored.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.
- R12: count_o is the low 16 bits of N - (d mod N) in modes 2, 3, 6 and 7. In the other modes it is the low 16 bits of N - d while d < N, and 0 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one tick per asserted cycle |
| gate_i | input | 1 | Gate level, registered every clock |
| ld_stb_i | input | 1 | Load strobe for mode and count |
| ld_mode_i | input | 3 | Mode code taken on a load |
| ld_count_i | input | 16 | Initial count taken on a load (0 means 65536) |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Current down-count value |

## Verification
A tick or load sampled at a rising edge is visible on out_o and count_o right after that same edge, because both outputs decode registered state. A gate change affects the tick taken one edge later. The bench drives every input at the falling edge and steps its reference model once per clock. That model carries its own copy of the previous gate level. It then compares both outputs at the following falling edge, so every comparison lands exactly one edge after the stimulus that caused it.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam logic [2:0] MODE_TERM   = 3'd0;
  localparam logic [2:0] MODE_ONESH  = 3'd1;
  localparam logic [2:0] MODE_RATE   = 3'd2;
  localparam logic [2:0] MODE_SQUARE = 3'd3;
  localparam logic [2:0] MODE_SWSTB  = 3'd4;
  localparam logic [2:0] MODE_HWSTB  = 3'd5;

  // Codes 2, 3, 6 and 7 repeat; bit 1 marks them.
  function automatic logic is_periodic(input logic [2:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/itc_setup.sv
module itc_setup #(
  parameter int CW       = 16,
  parameter bit GATE_RST = 1'b1,
  localparam int NW      = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          ld_stb_i,
  input  logic [2:0]    ld_mode_i,
  input  logic [CW-1:0] ld_count_i,
  output logic [2:0]    mode_o,
  output logic [NW-1:0] n_o,
  output logic          gate_o
);
  import itc_pkg::*;

  localparam logic [NW-1:0] FULL = NW'(1) << CW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_SQUARE;
      n_o    <= FULL;
      gate_o <= GATE_RST;
    end else begin
      gate_o <= gate_i;
      if (ld_stb_i) begin
        mode_o <= ld_mode_i;
        n_o    <= (ld_count_i == '0) ? FULL : {1'b0, ld_count_i};
      end
    end
  end
endmodule

// File: rtl/itc_elapsed.sv
module itc_elapsed #(
  parameter int CW  = 16,
  localparam int NW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ld_stb_i,
  input  logic [2:0]    mode_i,
  input  logic [NW-1:0] n_i,
  input  logic          gate_i,
  output logic [NW-1:0] elap_o,
  output logic          started_o
);
  import itc_pkg::*;

  logic periodic;
  assign periodic = is_periodic(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elap_o    <= '0;
      started_o <= 1'b0;
    end else if (ld_stb_i) begin
      elap_o    <= '0;
      started_o <= 1'b0;
    end else if (tick_i) begin
      if (periodic) begin
        if (gate_i) begin
          elap_o    <= (elap_o == n_i - NW'(1)) ? '0 : elap_o + NW'(1);
          started_o <= 1'b1;
        end
      end else if (elap_o <= n_i) begin
        // saturate at N+1: past the terminal tick nothing changes
        elap_o <= elap_o + NW'(1);
      end
    end
  end
endmodule

// File: rtl/itc_wave.sv
module itc_wave #(
  parameter int CW  = 16,
  localparam int NW = CW + 1
) (
  input  logic [2:0]    mode_i,
  input  logic [NW-1:0] n_i,
  input  logic [NW-1:0] elap_i,
  input  logic          started_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);
  import itc_pkg::*;

  logic [NW-1:0] half;
  logic [NW-1:0] remain;

  assign half = (n_i + NW'(1)) >> 1;

  always_comb begin
    if (is_periodic(mode_i)) begin
      out_o = mode_i[0] ? (elap_i < half) : (started_i && elap_i == '0);
    end else begin
      case (mode_i)
        MODE_TERM:  out_o = (elap_i >= n_i);
        MODE_ONESH: out_o = (elap_i < n_i);
        default:    out_o = (elap_i == n_i);
      endcase
    end
  end

  always_comb begin
    if (!is_periodic(mode_i) && elap_i >= n_i) remain = '0;
    else                                       remain = n_i - elap_i;
  end

  assign count_o = remain[CW-1:0];
endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel #(
  parameter int CW       = 16,
  parameter bit GATE_RST = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          ld_stb_i,
  input  logic [2:0]    ld_mode_i,
  input  logic [CW-1:0] ld_count_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);
  localparam int NW = CW + 1;

  logic [2:0]    mode_q;
  logic [NW-1:0] n_q;
  logic          gate_q;
  logic [NW-1:0] elap_q;
  logic          started_q;

  itc_setup #(.CW(CW), .GATE_RST(GATE_RST)) u_setup (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate_i), .ld_stb_i(ld_stb_i),
    .ld_mode_i(ld_mode_i), .ld_count_i(ld_count_i),
    .mode_o(mode_q), .n_o(n_q), .gate_o(gate_q)
  );

  itc_elapsed #(.CW(CW)) u_elapsed (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ld_stb_i(ld_stb_i),
    .mode_i(mode_q), .n_i(n_q), .gate_i(gate_q),
    .elap_o(elap_q), .started_o(started_q)
  );

  itc_wave #(.CW(CW)) u_wave (
    .mode_i(mode_q), .n_i(n_q), .elap_i(elap_q), .started_i(started_q),
    .out_o(out_o), .count_o(count_o)
  );
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int CW  = 16,
  localparam int NW = CW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          ld_stb_i,
  input logic [CW-1:0] ld_count_i,
  input logic          out_o,
  input logic [CW-1:0] count_o,
  input logic [2:0]    mode_q,
  input logic [NW-1:0] n_q,
  input logic          gate_q
);
  // R8: a load shows its count on the next cycle
  a_r8_load_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_stb_i |=> (count_o == $past(ld_count_i)));

  // R9: nothing moves without a tick or a load
  a_r9_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_stb_i) |=> ($stable(count_o) && $stable(out_o)));

  // R2: mode 0 output is sticky until reload
  a_r2_term_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd0 && out_o && !ld_stb_i) |=> out_o);

  // R6: strobe lasts a single tick
  a_r6_strobe_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == 3'd4 || mode_q == 3'd5) && out_o && tick_i && !ld_stb_i) |=> !out_o);

  // R10: periodic modes freeze with the gate low
  a_r10_gate_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && !gate_q && !ld_stb_i) |=> $stable(count_o));

  // R4: rate pulse drops after one counted tick when N exceeds 1
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && !mode_q[0] && out_o && tick_i && gate_q && !ld_stb_i
     && n_q > NW'(1)) |=> !out_o);
endmodule

bind interval_timer_channel itc_checker #(.CW(CW)) u_itc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ld_stb_i(ld_stb_i),
  .ld_count_i(ld_count_i), .out_o(out_o), .count_o(count_o),
  .mode_q(mode_q), .n_q(n_q), .gate_q(gate_q)
);

// File: tb/test_interval_timer_channel.sv
`timescale 1ns/1ps
module test_interval_timer_channel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        ld_stb_i = 1'b0;
  logic [2:0]  ld_mode_i = '0;
  logic [15:0] ld_count_i = '0;
  logic        out_o;
  logic [15:0] count_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  int m_mode, m_n, m_d;
  bit m_gp;

  always #10 clk_i = ~clk_i;  // 50 MHz

  interval_timer_channel #(.CW(16), .GATE_RST(1'b1)) i_interval_timer_channel (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .gate_i(gate_i),
    .ld_stb_i(ld_stb_i), .ld_mode_i(ld_mode_i), .ld_count_i(ld_count_i),
    .out_o(out_o), .count_o(count_o)
  );

  function automatic bit periodic(int m);
    return (m == 2 || m == 3 || m == 6 || m == 7);
  endfunction

  function automatic bit exp_out();
    case (m_mode)
      0:       return m_d >= m_n;
      1:       return m_d < m_n;
      2, 6:    return (m_d != 0) && (m_d % m_n == 0);
      3, 7:    return (m_d % m_n) < ((m_n + 1) / 2);
      default: return m_d == m_n;
    endcase
  endfunction

  function automatic int exp_cnt();
    if (periodic(m_mode)) return (m_n - m_d % m_n) & 16'hFFFF;
    if (m_d >= m_n) return 0;
    return (m_n - m_d) & 16'hFFFF;
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d N %0d d %0d)",
               tag, act, exp, m_mode, m_n, m_d);
    end
  endtask

  // called just after a falling edge
  task automatic step(bit ld, int md, int cn, bit tk, bit gt, string tag = "");
    ld_stb_i   = ld;
    ld_mode_i  = md[2:0];
    ld_count_i = cn[15:0];
    tick_i     = tk;
    gate_i     = gt;
    if (ld) begin
      m_mode = md;
      m_n    = (cn == 0) ? 65536 : cn;
      m_d    = 0;
    end else if (tk && (!periodic(m_mode) || m_gp)) begin
      m_d++;
    end
    m_gp = gt;
    @(posedge clk_i);
    @(negedge clk_i);
    check((tag == "") ? mode_tag(m_mode) : tag, int'(out_o), int'(exp_out()));
    check((tag == "") ? "R12" : tag, int'(count_o), exp_cnt());
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 195000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_mode = 3; m_n = 65536; m_d = 0; m_gp = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1: reset defaults
    check("R1", int'(out_o), 1);
    check("R1", int'(count_o), 0);
    // R1: gate register starts at GATE_RST=1 so this first tick counts
    step(0, 0, 0, 1, 0, "R1");

    // R9: no tick, no change
    step(1, 0, 5, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R9");
    // R10: gate ignored in mode 0
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, "R10");
    // R10: gate low freezes mode 2
    step(1, 2, 4, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 1, "R10");
    // R8: load with a simultaneous tick restarts at zero
    step(1, 3, 7, 1, 1, "R8");
    step(0, 0, 0, 1, 1, "R8");

    // every mode with odd and even counts, including N=1 and N=2
    for (int md = 0; md < 8; md++) begin
      for (int k = 0; k < 4; k++) begin
        int cn;
        cn = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 6;
        step(1, md, cn, 0, 1);
        for (int i = 0; i < 3 * cn + 4; i++) step(0, 0, 0, 1, 1);
      end
    end

    // constrained random: small counts, sparse ticks, gate flips, reloads
    for (int it = 0; it < 60; it++) begin
      int md, cn, len;
      bit g;
      md  = int'($urandom_range(0, 7));
      cn  = int'($urandom_range(1, 24));
      len = 3 * cn + 8;
      g   = 1'b1;
      step(1, md, cn, $urandom_range(0, 1), g);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 7) == 0) g = ~g;
        if ($urandom_range(0, 40) == 0)
          step(1, md, int'($urandom_range(1, 24)), $urandom_range(0, 1), g, "R8");
        else
          step(0, 0, 0, ($urandom_range(0, 3) != 0), g);
      end
    end

    // R7: zero count in mode 3 spans 65536 ticks, half high
    step(1, 3, 0, 0, 1, "R7");
    for (int i = 0; i < 65540; i++) step(0, 0, 0, 1, 1, "R7");
    // R7: zero count in mode 0 starts at the full count
    step(1, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, 1, "R7");

    finish_run();
  end
endmodule